// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic stage of an 8-bit accumulator machine. Each cycle the surrounding datapath gives it the accumulator, one operand byte, the current carry flag, an operation code and the raw instruction byte. The operand byte may come from a register, an immediate or memory. In the same cycle the block returns the new byte, a strobe that says whether the destination is written, and six status flags: sign, zero, half-carry, parity/overflow, subtract and carry.

The parity/overflow flag changes meaning with the operation. Arithmetic reports signed overflow through it, the logical group reports even parity through it, and the unary forms have fixed trigger values. The subtract flag records whether the last operation was of the subtracting kind. Increment and decrement leave the carry flag as it was. The block also extracts the register-file index from the instruction byte, using the field that the current operation class implies.

Top module: `alu8_core`

## Requirements
- R1: `op_i` encodings are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, XOR=5, OR=6, CP=7, NEG=8, INC=9, DEC=10. Codes 11 to 15 are reserved. For a reserved code, `result_o` equals `acc_i`, `wr_en_o` is 0 and all six flags are 0.
- R2: For every defined operation, the sign flag equals bit 7 of `result_o`, and the zero flag is 1 exactly when `result_o` is 0x00.
- R3: ADD gives `acc_i + opnd_i` modulo 256, and ADC adds `carry_i` as well. Carry is the carry out of bit 7 and half-carry is the carry out of bit 3. Parity/overflow is two's-complement signed overflow. Subtract is 0.
- R4: SUB gives `acc_i - opnd_i` modulo 256, and SBC also subtracts `carry_i`. Carry is the borrow out of bit 7 and half-carry is the borrow out of bit 3. Parity/overflow is signed overflow. Subtract is 1.
- R5: CP drives `result_o` and all flags exactly as SUB does, but `wr_en_o` is 0. Every other defined operation has `wr_en_o` = 1.
- R6: AND gives the bitwise AND. Half-carry is 1, carry and subtract are 0, and parity/overflow is 1 when the result has an even number of one bits.
- R7: OR and XOR give the bitwise OR and XOR. Half-carry, carry and subtract are 0, and parity/overflow is 1 when the result has an even number of one bits.
- R8: NEG gives `0 - acc_i` modulo 256. Parity/overflow is 1 only when `acc_i` is 0x80, carry is 1 when `acc_i` is nonzero, half-carry is 1 when `acc_i[3:0]` is nonzero, and subtract is 1.
- R9: INC gives `opnd_i + 1` modulo 256. Parity/overflow is 1 only when `opnd_i` is 0x7F, half-carry is 1 when `opnd_i[3:0]` is 0xF, subtract is 0, and carry equals `carry_i`.
- R10: DEC gives `opnd_i - 1` modulo 256. Parity/overflow is 1 only when `opnd_i` is 0x80, half-carry is 1 when `opnd_i[3:0]` is 0x0, subtract is 1, and carry equals `carry_i`.
- R11: `src_sel_o` is `opcode_i[5:3]` for INC and DEC. For every other code it is `opcode_i[2:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte (register, immediate or memory) |
| carry_i | input | 1 | Carry flag currently held |
| op_i | input | 4 | Operation code (see R1) |
| opcode_i | input | 8 | Instruction byte, used for index decode |
| src_sel_o | output | 3 | Register index taken from the instruction byte |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Destination write strobe |
| f_sign_o | output | 1 | Sign flag |
| f_zero_o | output | 1 | Zero flag |
| f_half_o | output | 1 | Half-carry flag |
| f_pv_o | output | 1 | Parity/overflow flag |
| f_sub_o | output | 1 | Subtract flag |
| f_carry_o | output | 1 | Carry flag |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same cycle as the input that exposes it. A fault in the shared adder, such as an inverted borrow, a wrong half-carry tap or a wrong overflow term, shows up in several operation classes at once. A fault in the flag-selection mux shows up only in the class it affects, for example an INC that disturbs carry or an OR that reports overflow instead of parity. The bench sweeps every accumulator value against a spread of operands that includes 0x7F, 0x80 and both nibble boundaries, with the carry input both clear and set. A mismatch is therefore reported in the cycle in which the faulty input is applied.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CP  = 4'd7,
    OP_NEG = 4'd8,
    OP_INC = 4'd9,
    OP_DEC = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic pv;
    logic sub;
    logic carry;
  } alu_flags_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_sel_e;

  // Operations that feed the shared adder/subtractor.
  function automatic logic uses_adder(input logic [OP_W-1:0] op);
    return (op <= OP_SBC) || (op == OP_CP) || (op == OP_NEG) ||
           (op == OP_INC) || (op == OP_DEC);
  endfunction

  // Operations that set the subtract flag.
  function automatic logic is_subtract(input logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
           (op == OP_NEG) || (op == OP_DEC);
  endfunction

  // Single-operand forms whose register index sits in the upper field.
  function automatic logic is_unary_reg(input logic [OP_W-1:0] op);
    return (op == OP_INC) || (op == OP_DEC);
  endfunction

  function automatic logic is_defined(input logic [OP_W-1:0] op);
    return op <= OP_DEC;
  endfunction

endpackage

// File: rtl/alu8_src_sel.sv
module alu8_src_sel #(
  parameter int OPC_W     = 8,
  parameter int IDX_W     = 3,
  parameter int ALU_LSB   = 0,
  parameter int UNARY_LSB = 3
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             unary,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] low_field;
  logic [IDX_W-1:0] mid_field;

  assign low_field = opcode[ALU_LSB +: IDX_W];
  assign mid_field = opcode[UNARY_LSB +: IDX_W];
  assign idx       = unary ? mid_field : low_field;
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout,   // carry, or borrow when sub=1
  output logic              hout,   // carry/borrow out of the low half
  output logic              ovf     // signed overflow
);
  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] y_eff;
  logic              c_eff;
  logic [HALF_W:0]   low_sum;
  logic [DATA_W:0]   full_sum;

  always_comb begin
    y_eff    = sub ? ~y : y;
    c_eff    = sub ? ~cin : cin;
    low_sum  = {1'b0, x[HALF_W-1:0]} + {1'b0, y_eff[HALF_W-1:0]}
             + {{HALF_W{1'b0}}, c_eff};
    full_sum = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
    sum      = full_sum[DATA_W-1:0];
    cout     = full_sum[DATA_W] ^ sub;
    hout     = low_sum[HALF_W] ^ sub;
    ovf      = (x[MSB] == y_eff[MSB]) && (full_sum[MSB] != x[MSB]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_sel_e        sel,
  output logic [DATA_W-1:0] res,
  output logic              par_even
);
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] or_v;
  logic [DATA_W-1:0] xor_v;
  logic [DATA_W:0]   par_chain;

  assign par_chain[0] = 1'b1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign and_v[i]       = a[i] & b[i];
    assign or_v[i]        = a[i] | b[i];
    assign xor_v[i]       = a[i] ^ b[i];
    assign par_chain[i+1] = par_chain[i] ^ res[i];
  end

  always_comb begin
    unique case (sel)
      LG_AND:  res = and_v;
      LG_XOR:  res = xor_v;
      default: res = or_v;
    endcase
  end

  assign par_even = par_chain[DATA_W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OPC_W     = 8,
  parameter int IDX_W     = 3,
  parameter int ALU_LSB   = 0,
  parameter int UNARY_LSB = 3
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [IDX_W-1:0]  src_sel_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              f_sign_o,
  output logic              f_zero_o,
  output logic              f_half_o,
  output logic              f_pv_o,
  output logic              f_sub_o,
  output logic              f_carry_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ZERO    = '0;

  // Adder operand selection, visible to the assertions.
  logic [DATA_W-1:0] add_x, add_y, add_sum;
  logic              add_cin, add_sub, add_cout, add_hout, add_ovf;
  logic [DATA_W-1:0] lg_res;
  logic              lg_par;
  logic_sel_e        lg_sel;
  alu_flags_t        flags;
  logic [DATA_W-1:0] res;

  alu8_src_sel #(
    .OPC_W(OPC_W), .IDX_W(IDX_W), .ALU_LSB(ALU_LSB), .UNARY_LSB(UNARY_LSB)
  ) u_sel (
    .opcode (opcode_i),
    .unary  (is_unary_reg(op_i)),
    .idx    (src_sel_o)
  );

  always_comb begin
    add_x   = acc_i;
    add_y   = opnd_i;
    add_cin = 1'b0;
    add_sub = 1'b0;
    unique case (op_i)
      OP_ADC: add_cin = carry_i;
      OP_SUB,
      OP_CP:  add_sub = 1'b1;
      OP_SBC: begin add_sub = 1'b1; add_cin = carry_i; end
      OP_NEG: begin add_x = ZERO; add_y = acc_i; add_sub = 1'b1; end
      OP_INC: begin add_x = opnd_i; add_y = ONE; end
      OP_DEC: begin add_x = opnd_i; add_y = ONE; add_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_add (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sub  (add_sub),
    .sum  (add_sum),
    .cout (add_cout),
    .hout (add_hout),
    .ovf  (add_ovf)
  );

  always_comb begin
    unique case (op_i)
      OP_XOR:  lg_sel = LG_XOR;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a        (acc_i),
    .b        (opnd_i),
    .sel      (lg_sel),
    .res      (lg_res),
    .par_even (lg_par)
  );

  // Result and flag selection, with the guarding assertions alongside.
  always_comb begin
    flags = '0;
    res   = acc_i;
    if (uses_adder(op_i)) begin
      res         = add_sum;
      flags.half  = add_hout;
      flags.pv    = add_ovf;
      flags.carry = is_unary_reg(op_i) ? carry_i : add_cout;
    end else if (is_defined(op_i)) begin
      res         = lg_res;
      flags.half  = (op_i == OP_AND);
      flags.pv    = lg_par;
      flags.carry = 1'b0;
    end
    if (is_defined(op_i)) begin
      flags.sign = res[DATA_W-1];
      flags.zero = (res == ZERO);
      flags.sub  = is_subtract(op_i);
    end

    if (op_i == OP_ADD)
      p_add_wrap_r3: assert (add_cout == (add_sum < acc_i))
        else $error("ADD carry disagrees with wraparound");
    if (op_i == OP_SUB || op_i == OP_CP)
      p_sub_borrow_r4: assert (add_cout == (acc_i < opnd_i))
        else $error("SUB/CP borrow disagrees with magnitude compare");
    if (op_i == OP_NEG)
      p_neg_flags_r8: assert (add_ovf == (acc_i == MIN_NEG) &&
                              add_cout == (acc_i != ZERO))
        else $error("NEG overflow/carry rule broken");
    if (op_i == OP_INC)
      p_inc_ovf_r9: assert (add_ovf == (opnd_i == MAX_POS) &&
                            add_hout == (&opnd_i[HALF_W-1:0]))
        else $error("INC overflow/half rule broken");
    if (op_i == OP_DEC)
      p_dec_ovf_r10: assert (add_ovf == (opnd_i == MIN_NEG) &&
                             add_hout == (opnd_i[HALF_W-1:0] == '0))
        else $error("DEC overflow/half rule broken");
  end

  assign result_o  = res;
  assign wr_en_o   = is_defined(op_i) && (op_i != OP_CP);
  assign f_sign_o  = flags.sign;
  assign f_zero_o  = flags.zero;
  assign f_half_o  = flags.half;
  assign f_pv_o    = flags.pv;
  assign f_sub_o   = flags.sub;
  assign f_carry_o = flags.carry;
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc, opnd, opc;
  logic       cy;
  logic [3:0] op;
  logic [2:0] src_sel;
  logic [7:0] result;
  logic       wr_en, fs, fz, fh, fpv, fn, fc;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #5 clk = ~clk;

  alu8_core u_dut (
    .acc_i(acc), .opnd_i(opnd), .carry_i(cy), .op_i(op), .opcode_i(opc),
    .src_sel_o(src_sel), .result_o(result), .wr_en_o(wr_en),
    .f_sign_o(fs), .f_zero_o(fz), .f_half_o(fh), .f_pv_o(fpv),
    .f_sub_o(fn), .f_carry_o(fc)
  );

  function automatic string tag_of(int o);
    case (o)
      0, 1:    return "R3";
      2, 3:    return "R4";
      7:       return "R5";
      4:       return "R6";
      5, 6:    return "R7";
      8:       return "R8";
      9:       return "R9";
      10:      return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic bit even_par(int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return (ones % 2) == 0;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s op=%0d acc=%02h opnd=%02h cy=%0d actual=%0h expected=%0h",
               tag, what, op, acc, opnd, cy, act, exp);
      bad = 1;
    end
  endtask

  // Behavioural reference computed from the requirements, compared once per clock.
  task automatic apply(int o, int a, int b, int c, int code);
    int  r, s, t, e_h, e_v, e_c, e_n, e_w, e_src;
    bit  bad = 0;
    bit  defd;
    @(posedge clk);
    op = 4'(o); acc = 8'(a); opnd = 8'(b); cy = c[0]; opc = 8'(code);
    defd = (o <= 10);
    e_h = 0; e_v = 0; e_c = 0; e_n = 0; e_w = 1; r = a;
    case (o)
      0, 1: begin
        t = (o == 1) ? c : 0;
        s = a + b + t; r = s & 255; e_c = s > 255;
        e_h = ((a & 15) + (b & 15) + t) > 15;
        s = sgn(a) + sgn(b) + t; e_v = (s > 127) || (s < -128);
      end
      2, 3, 7: begin
        t = (o == 3) ? c : 0;
        s = a - b - t; r = s & 255; e_c = s < 0;
        e_h = ((a & 15) - (b & 15) - t) < 0;
        s = sgn(a) - sgn(b) - t; e_v = (s > 127) || (s < -128);
        e_n = 1; e_w = (o != 7);
      end
      4: begin r = a & b; e_h = 1; e_v = even_par(r); end
      5: begin r = a ^ b; e_v = even_par(r); end
      6: begin r = a | b; e_v = even_par(r); end
      8: begin
        r = (256 - a) & 255; e_v = (a == 128); e_c = (a != 0);
        e_h = (a & 15) != 0; e_n = 1;
      end
      9: begin
        r = (b + 1) & 255; e_v = (b == 127); e_h = (b & 15) == 15; e_c = c;
      end
      10: begin
        r = (b + 255) & 255; e_v = (b == 128); e_h = (b & 15) == 0;
        e_c = c; e_n = 1;
      end
      default: begin r = a; e_w = 0; end
    endcase
    e_src = (o == 9 || o == 10) ? ((code >> 3) & 7) : (code & 7);
    @(negedge clk);
    n_vec++;
    cmp(tag_of(o), "result", int'(result), r, bad);
    cmp(defd ? "R5" : "R1", "wr_en", int'(wr_en), e_w, bad);
    cmp(defd ? "R2" : "R1", "sign", int'(fs), defd ? (r >> 7) & 1 : 0, bad);
    cmp(defd ? "R2" : "R1", "zero", int'(fz), defd ? int'(r == 0) : 0, bad);
    cmp(tag_of(o), "half", int'(fh), e_h, bad);
    cmp(tag_of(o), "pv", int'(fpv), e_v, bad);
    cmp(tag_of(o), "sub", int'(fn), e_n, bad);
    cmp(tag_of(o), "carry", int'(fc), e_c, bad);
    cmp("R11", "src_sel", int'(src_sel), e_src, bad);
    if (bad) n_bad++;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int bvals[19];
    acc = '0; opnd = '0; cy = 1'b0; op = '0; opc = '0;
    for (int k = 0; k < 16; k++) bvals[k] = k * 17;
    bvals[16] = 8'h7F; bvals[17] = 8'h80; bvals[18] = 8'h01;
    // Reset-time vector: ADD of zeros gives zero result with the zero flag (R2, R3).
    apply(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    for (int o = 0; o <= 10; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 19; k++)
          for (int c = 0; c < 2; c++)
            apply(o, a, bvals[k], c, (a * 5 + k * 37 + c) & 255);
    // Reserved codes pass the accumulator through with nothing written (R1).
    for (int o = 11; o < 16; o++)
      for (int j = 0; j < 16; j++)
        apply(o, j * 16 + j, 255 - j, j & 1, j * 13);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule